// File: doc/BRIEF.md
# HD Link Scrambler and NRZI Encoder

This block is the last stage of a high-definition serial video transmit path. Each pixel clock it takes one 20-bit word, with luma in bits 19:10 and chroma in bits 9:0, and treats it as twenty consecutive bits of one serial stream, bit 0 first. It scrambles that stream with a self-synchronizing polynomial, NRZI-encodes the result, and registers the 20-bit output word for a downstream serializer. The pixel clock is 74.25 MHz or 74.25/1.001 MHz. The upstream stages have already inserted timing references, line numbers and CRCs and remapped protected codes.

Two level-style controls come from outside the pixel clock domain. Each passes through a two-flop synchronizer. The bypass control routes the input word around both coding stages. A rising edge on the clear control returns the scrambler history and the NRZI history to zero. Holding the clear control at either level has no further effect.

Top module: `sdi_scramble_nrzi`

## Requirements
- R1: The output is registered and follows the input word by exactly one clock in both modes. After the active-low asynchronous reset, the output and both coding histories are zero.
- R2: While the synchronized bypass level is 1, the output word equals the input word from the previous clock, bit for bit.
- R3: While the synchronized bypass level is 0, each scrambled bit is the input bit XOR the scrambled bits 4 and 9 positions earlier in the stream (generator x^9 + x^4 + 1). Within a word the bits run from bit 0 to bit 19, and the history carries from bit 19 of one word into bit 0 of the next.
- R4: Each output bit in encoding mode is its scrambled bit XOR the previous output bit of the stream (generator x + 1). Bit 0 of a word uses bit 19 of the previous encoded word.
- R5: A rising edge of the synchronized clear level zeroes both histories before the word captured in that cycle is coded. With a zero history, an all-zero word therefore encodes to all zeros.
- R6: Holding the clear control high, or low, over many words causes no further clearing. Coding continues from the running history.
- R7: A change on either control input made before clock edge k affects the word captured at edge k+2, the third rising edge that sees the new level, and no earlier word.
- R8: While bypassed, both coding histories hold their values. When bypass ends, coding resumes from the held history. A clear edge during bypass still zeroes the histories.
- R9: Asserting the asynchronous reset in mid-stream forces the output to zero at once and restarts coding from a zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_ctl | input | 1 | Unsynchronized bypass request, 1 = skip scrambler and NRZI |
| clear_ctl | input | 1 | Unsynchronized clear request; a rising edge zeroes the coding history |
| din | input | 20 | Input word, bits 19:10 luma, bits 9:0 chroma, bit 0 sent first |
| dout | output | 20 | Coded (or bypassed) word, one clock after din |

## Verification
The hardest situations to reach are the cycles around a control change. There, the word in flight must still be coded under the old setting, and the word two clocks later must take the new one. A clear edge that lands while bypass is active is just as hard, because its effect shows only once coding resumes. The bench drives each control edge a known number of cycles before chosen words and keeps its own three-deep history of the raw control levels. It then runs the bit-serial reference across the boundary, so a single cycle of slip in the synchronizer or the edge detector changes the expected words. A clear followed by an all-zero word gives a fixed expected output of zero. A long hold of the clear control shows that the history keeps running.

// File: rtl/sdi_scr_pkg.sv
package sdi_scr_pkg;

    // Path selected for the word being registered.
    typedef enum logic {
        MODE_ENCODE = 1'b0,
        MODE_PASS   = 1'b1
    } scr_mode_e;

    localparam int DEF_WORD_W   = 20;
    localparam int DEF_TAP_NEAR = 4;
    localparam int DEF_TAP_FAR  = 9;
    localparam int DEF_SYNC     = 2;

endpackage

// File: rtl/scr_ctrl_sync.sv
// Multi-flop synchronizer for one control level, with a single-cycle
// pulse on each rising edge of the synchronized level.
module scr_ctrl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_o,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        if (STAGES > 1) begin
            sync_d.chain = {sync_q.chain[STAGES-2:0], raw_in};
        end else begin
            sync_d.chain = raw_in;
        end
        sync_d.prev = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.chain[STAGES-1];
    assign rise_o  = sync_q.chain[STAGES-1] & ~sync_q.prev;

endmodule

// File: rtl/scr_word_coder.sv
// Combinational coding of one word: bit 0 to bit MSB, scrambler then NRZI.
// History is the last TAP_FAR scrambled bits, oldest at index 0.
module scr_word_coder #(
    parameter int WORD_W   = 20,
    parameter int TAP_NEAR = 4,
    parameter int TAP_FAR  = 9
) (
    input  logic [WORD_W-1:0]  word_in,
    input  logic [TAP_FAR-1:0] hist_in,
    input  logic               nrzi_in,
    output logic [WORD_W-1:0]  word_out,
    output logic [TAP_FAR-1:0] hist_out,
    output logic               nrzi_out
);

    localparam int EXT_W = TAP_FAR + WORD_W;

    logic [EXT_W-1:0]  stream;
    logic [WORD_W-1:0] line;

    always_comb begin
        stream              = '0;
        stream[TAP_FAR-1:0] = hist_in;
        for (int i = 0; i < WORD_W; i++) begin
            stream[TAP_FAR+i] = word_in[i]
                              ^ stream[TAP_FAR+i-TAP_NEAR]
                              ^ stream[i];
        end
    end

    always_comb begin
        line    = '0;
        line[0] = stream[TAP_FAR] ^ nrzi_in;
        for (int i = 1; i < WORD_W; i++) begin
            line[i] = stream[TAP_FAR+i] ^ line[i-1];
        end
    end

    assign word_out = line;
    assign hist_out = stream[EXT_W-1 -: TAP_FAR];
    assign nrzi_out = line[WORD_W-1];

endmodule

// File: rtl/sdi_scramble_nrzi.sv
module sdi_scramble_nrzi
    import sdi_scr_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int TAP_NEAR    = DEF_TAP_NEAR,
    parameter int TAP_FAR     = DEF_TAP_FAR,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass_ctl,
    input  logic              clear_ctl,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    localparam int HIST_W = TAP_FAR;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic              nrzi;
        logic [WORD_W-1:0] word;
    } coder_t;

    coder_t st_d, st_q;

    logic              byp_s;
    logic              byp_rise_unused;
    logic              clr_level_unused;
    logic              clr_pulse;
    logic [HIST_W-1:0] base_hist;
    logic              base_nrzi;
    logic [WORD_W-1:0] enc_word;
    logic [HIST_W-1:0] enc_hist;
    logic              enc_nrzi;
    scr_mode_e         mode;

    scr_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_bypass (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  (bypass_ctl),
        .level_o (byp_s),
        .rise_o  (byp_rise_unused)
    );

    scr_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  (clear_ctl),
        .level_o (clr_level_unused),
        .rise_o  (clr_pulse)
    );

    // A clear edge acts before the current word is coded.
    assign base_hist = clr_pulse ? '0   : st_q.hist;
    assign base_nrzi = clr_pulse ? 1'b0 : st_q.nrzi;

    scr_word_coder #(
        .WORD_W   (WORD_W),
        .TAP_NEAR (TAP_NEAR),
        .TAP_FAR  (TAP_FAR)
    ) u_coder (
        .word_in  (din),
        .hist_in  (base_hist),
        .nrzi_in  (base_nrzi),
        .word_out (enc_word),
        .hist_out (enc_hist),
        .nrzi_out (enc_nrzi)
    );

    assign mode = byp_s ? MODE_PASS : MODE_ENCODE;

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_PASS: begin
                st_d.word = din;
                st_d.hist = base_hist;
                st_d.nrzi = base_nrzi;
            end
            default: begin
                st_d.word = enc_word;
                st_d.hist = enc_hist;
                st_d.nrzi = enc_nrzi;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.word;

endmodule

// File: rtl/sdi_scr_checker.sv
module sdi_scr_checker #(
    parameter int WORD_W = 20,
    parameter int HIST_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] din,
    input logic [WORD_W-1:0] dout,
    input logic              byp_s,
    input logic              clr_pulse,
    input logic [HIST_W-1:0] hist_q,
    input logic              nrzi_q
);

    // R2: bypassed words pass unchanged with one clock of latency
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        byp_s |=> (dout == $past(din)));

    // R4: the NRZI history tracks the last bit sent in encoding mode
    a_r4_nrzi_tracks_msb: assert property (@(posedge clk) disable iff (!rst_n)
        !byp_s |=> (nrzi_q == dout[WORD_W-1]));

    // R5: a clear edge followed by a zero word yields zero output and history
    a_r5_clear_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !byp_s && (din == '0)) |=>
            ((dout == '0) && (hist_q == '0) && !nrzi_q));

    // R6: a held clear level produces only a single pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse);

    // R8: history is frozen while bypassed without a clear edge
    a_r8_hold_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_s && !clr_pulse) |=> ($stable(hist_q) && $stable(nrzi_q)));

endmodule

bind sdi_scramble_nrzi sdi_scr_checker #(
    .WORD_W (WORD_W),
    .HIST_W (HIST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .dout      (dout),
    .byp_s     (byp_s),
    .clr_pulse (clr_pulse),
    .hist_q    (st_q.hist),
    .nrzi_q    (st_q.nrzi)
);

// File: tb/sdi_scramble_nrzi_test.sv
module sdi_scramble_nrzi_test;

    localparam int W  = 20;
    localparam int TN = 4;
    localparam int TF = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bypass_ctl = 1'b0;
    logic         clear_ctl = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    logic [TF-1:0] m_hist;
    logic          m_nrzi;
    logic          hb1, hb2;        // raw bypass, 1 and 2 steps back
    logic          hc1, hc2, hc3;   // raw clear, 1..3 steps back

    sdi_scramble_nrzi uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass_ctl (bypass_ctl),
        .clear_ctl  (clear_ctl),
        .din        (din),
        .dout       (dout)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dout actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_hist = '0; m_nrzi = 1'b0;
        hb1 = 0; hb2 = 0; hc1 = 0; hc2 = 0; hc3 = 0;
    endtask

    function automatic logic [W-1:0] encode(input logic [W-1:0] w);
        logic [W-1:0] o;
        logic sb;
        for (int i = 0; i < W; i++) begin
            sb     = w[i] ^ m_hist[TF-TN] ^ m_hist[0];
            m_hist = {sb, m_hist[TF-1:1]};
            m_nrzi = sb ^ m_nrzi;
            o[i]   = m_nrzi;
        end
        return o;
    endfunction

    // One word: drive at negedge, capture at posedge, check mid-high phase.
    task automatic step(input logic [W-1:0] w, input logic byp,
                        input logic clr, input string tag);
        logic [W-1:0] exp;
        logic eff_byp, pulse;
        @(negedge clk);
        din = w; bypass_ctl = byp; clear_ctl = clr;
        eff_byp = hb2;                 // R7: level set two steps earlier
        pulse   = hc2 & ~hc3;
        if (pulse) begin
            m_hist = '0; m_nrzi = 1'b0;
        end
        if (eff_byp) exp = w;
        else         exp = encode(w);
        hc3 = hc2; hc2 = hc1; hc1 = clr;
        hb2 = hb1; hb1 = byp;
        @(posedge clk);
        #5;
        check(tag, dout, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bypass_ctl = 1'b0; clear_ctl = 1'b0; din = '0;
        #2;
        check("R9", dout, '0);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        model_clear();
        #35;
        check("R1", dout, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3/R4: sweep all 10-bit luma codes against complementary chroma
        for (int v = 0; v < 1024; v++) begin
            step({v[9:0], ~v[9:0]}, 1'b0, 1'b0, (v < 512) ? "R3" : "R4");
        end
        // R4: single bits at each position stress the cross-word carry
        for (int b = 0; b < W; b++) begin
            step(W'(1) << b, 1'b0, 1'b0, "R4");
            step('0, 1'b0, 1'b0, "R4");
        end

        // R7: bypass request; next two words still coded, then pass
        step(20'hA5A5A, 1'b1, 1'b0, "R7");
        step(20'h12345, 1'b1, 1'b0, "R7");
        // R2: pass-through sweep
        for (int v = 0; v < 256; v++) begin
            step({v[7:0], 4'h9, v[7:0]}, 1'b1, 1'b0, "R2");
        end
        // R8: leave bypass, coding resumes from held history
        step(20'hFFFFF, 1'b0, 1'b0, "R7");
        step(20'h00001, 1'b0, 1'b0, "R7");
        for (int v = 0; v < 64; v++) begin
            step(W'($urandom), 1'b0, 1'b0, "R8");
        end

        // R5: clear edge; zero word in the clearing cycle gives zero
        step(20'h3C3C3, 1'b0, 1'b1, "R5");
        step(20'h0F0F0, 1'b0, 1'b1, "R5");
        step('0, 1'b0, 1'b1, "R5");
        check("R5", dout, '0);
        for (int v = 0; v < 40; v++) begin
            step(W'($urandom), 1'b0, 1'b1, "R6");   // held high
        end
        for (int v = 0; v < 40; v++) begin
            step(W'($urandom), 1'b0, 1'b0, "R6");   // held low
        end

        // R8: clear edge while bypassed, then resume
        step(20'h55555, 1'b1, 1'b0, "R8");
        step(20'h55555, 1'b1, 1'b0, "R8");
        step(20'h55555, 1'b1, 1'b1, "R8");
        for (int v = 0; v < 6; v++) begin
            step(W'($urandom), 1'b1, 1'b1, "R8");
        end
        step(20'h0, 1'b0, 1'b0, "R8");
        for (int v = 0; v < 40; v++) begin
            step(W'($urandom), 1'b0, 1'b0, "R8");
        end

        // R9: reset mid-stream, restart from zero history
        do_reset();
        for (int v = 0; v < 100; v++) begin
            step(W'($urandom), 1'b0, 1'b0, "R9");
        end
        // R1: latency in both modes under fast control toggling
        for (int v = 0; v < 60; v++) begin
            step(W'($urandom), v[2], v[3], "R1");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

endmodule